// File: doc/BRIEF.md
# Dual Palette Colour Lookup with Byte-Serial Host Access

This block holds two colour palettes of 256 entries each, every entry a 24-bit red/green/blue triplet. A host reaches them one byte at a time through a small 8-bit register interface. It loads a write index or a read index, then streams the colour bytes through a single data register. An internal sequencer keeps the red and green bytes of a write until the blue byte arrives, then stores the whole triplet at once. For reads, loading the read index sets the pointer one entry ahead, so each data read returns a byte of the entry just behind the pointer.

The two palettes are selected separately. A state-register bit picks the palette the host reaches, and a second bit picks the palette the display side reads. The display side takes a pixel index every cycle, ANDs it with the mask register and returns the three components one clock later. A width bit emulates 6-bit colour cells: bytes stored from the host are shifted up by two, and bytes returned to the host are shifted down by two. A configuration bit chooses whether a read of the read-index register returns the pointer or the access mode.

Register addresses on `host_addr`: 0 data, 1 write-index, 2 read-index, 3 mask, 4 state, 5 config.

Top module: `pal_access_ctrl`

## Requirements
- R1: After reset the pointer is 0, the colour phase is red, the mode is write, the mask is 0xFF, and the host select, display select, width and config bits are 0. The state register then reads 0x01.
- R2: A write to the write-index register (address 1) loads the pointer with the byte, sets the mode to write and the phase to red. A read of address 1 returns the pointer.
- R3: A write to the read-index register (address 2) loads the pointer with the byte plus one (modulo 256), sets the mode to read and the phase to red.
- R4: A data write (address 0) in the red or green phase only latches the byte. In the blue phase it stores {held red, held green, byte} at the pointer in the palette chosen by state bit 3. A partly written triplet leaves the palette unchanged.
- R5: A data read (address 0) returns the red, green or blue byte, as chosen by the current phase, of the entry at pointer minus one (modulo 256) in the host-selected palette.
- R6: Each data access advances the phase red→green→blue→red. The pointer increments (modulo 256) only on the blue→red step.
- R7: The state register (address 4) reads {width[7], display select[6], mode[5:4], host select[3], phase[2:0]}. The phase is encoded 1=red, 2=green, 4=blue and the mode 0=write, 3=read. Writes change only bits 3, 6 and 7.
- R8: With the width bit set, each stored byte is shifted left by 2 and each returned data byte is shifted right by 2. With the bit clear, bytes pass unchanged.
- R9: With config bit 0 (address 5) clear, a read of address 2 returns the pointer. With the bit set, it returns the mode code in bits 1:0 and zero in bits 7:2.
- R10: The display outputs carry, one clock after `pix_idx` is presented, the entry at (pix_idx AND mask) in the palette chosen by state bit 6. The mask is at address 3.
- R11: A host read (`host_sel` high, `host_we` low) puts its result on `host_rdata` one clock later. `host_rdata` holds that value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| pix_idx | input | 8 | Display pixel index |
| pix_red | output | 8 | Display red component |
| pix_grn | output | 8 | Display green component |
| pix_blu | output | 8 | Display blue component |

## Verification
The assertions assume that the host makes at most one access per cycle, that each access lasts exactly one cycle, and that `host_addr` holds only the six decoded values when `host_sel` is high. The stimulus issues every access through single-cycle tasks that return `host_sel` low at the following falling edge, and it uses only the listed addresses. It makes no host access during the two cycles after reset while the internal reset is still being released.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [2:0] {
    CLR_R = 3'b001,
    CLR_G = 3'b010,
    CLR_B = 3'b100
  } colour_e;

  typedef enum logic [1:0] {
    MD_WR = 2'b00,
    MD_RD = 2'b11
  } mode_e;

  localparam logic [2:0] RA_DATA  = 3'd0;
  localparam logic [2:0] RA_WIDX  = 3'd1;
  localparam logic [2:0] RA_RIDX  = 3'd2;
  localparam logic [2:0] RA_MASK  = 3'd3;
  localparam logic [2:0] RA_STATE = 3'd4;
  localparam logic [2:0] RA_CFG   = 3'd5;

  localparam int ST_HSEL = 3;
  localparam int ST_DSEL = 6;
  localparam int ST_VGA  = 7;
  localparam int VGA_SHIFT = 2;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_wr,
  input  logic              ld_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [IDX_W-1:0]  ld_val,
  input  logic [COMP_W-1:0] dat_in,
  output logic [IDX_W-1:0]  idx,
  output colour_e           colour,
  output mode_e             mode,
  output logic [COMP_W-1:0] hold_r,
  output logic [COMP_W-1:0] hold_g,
  output logic              commit
);
  logic [IDX_W-1:0]  idx_n;
  colour_e           colour_n;
  mode_e             mode_n;
  logic [COMP_W-1:0] hold_r_n;
  logic [COMP_W-1:0] hold_g_n;
  logic              step_en;

  assign step_en = ld_wr | ld_rd | dat_wr | dat_rd;

  always_comb begin
    idx_n    = idx;
    colour_n = colour;
    mode_n   = mode;
    hold_r_n = hold_r;
    hold_g_n = hold_g;
    commit   = 1'b0;
    if (ld_wr) begin
      idx_n    = ld_val;
      colour_n = CLR_R;
      mode_n   = MD_WR;
    end else if (ld_rd) begin
      idx_n    = ld_val + 1'b1;
      colour_n = CLR_R;
      mode_n   = MD_RD;
    end else if (dat_wr || dat_rd) begin
      unique case (colour)
        CLR_R: begin
          if (dat_wr) hold_r_n = dat_in;
          colour_n = CLR_G;
        end
        CLR_G: begin
          if (dat_wr) hold_g_n = dat_in;
          colour_n = CLR_B;
        end
        CLR_B: begin
          commit   = dat_wr;
          colour_n = CLR_R;
          idx_n    = idx + 1'b1;
        end
        default: colour_n = CLR_R;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      colour <= CLR_R;
      mode   <= MD_WR;
      hold_r <= '0;
      hold_g <= '0;
    end else if (step_en) begin
      idx    <= idx_n;
      colour <= colour_n;
      mode   <= mode_n;
      hold_r <= hold_r_n;
      hold_g <= hold_g_n;
    end
  end
endmodule

// File: rtl/pal_xlate.sv
module pal_xlate
  import pal_pkg::*;
#(
  parameter int COMP_W  = 8,
  parameter bit TO_CELL = 1'b1
) (
  input  logic              narrow,
  input  logic [COMP_W-1:0] din,
  output logic [COMP_W-1:0] dout
);
  generate
    if (TO_CELL) begin : g_up
      assign dout = narrow ? (din << VGA_SHIFT) : din;
    end else begin : g_down
      assign dout = narrow ? (din >> VGA_SHIFT) : din;
    end
  endgenerate
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                wsel,
  input  logic [IDX_W-1:0]    waddr,
  input  logic [3*COMP_W-1:0] wentry,
  input  logic                hsel,
  input  logic [IDX_W-1:0]    haddr,
  output logic [3*COMP_W-1:0] hentry,
  input  logic                dsel,
  input  logic [IDX_W-1:0]    daddr,
  output logic [3*COMP_W-1:0] dentry
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 3 * COMP_W;

  logic [ENT_W-1:0] bank [2][DEPTH];

  always_ff @(posedge clk) begin
    if (we) bank[wsel][waddr] <= wentry;
  end

  assign hentry = bank[hsel][haddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dentry <= '0;
    else        dentry <= bank[dsel][daddr];
  end
endmodule

// File: rtl/pal_access_ctrl.sv
module pal_access_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [COMP_W-1:0] host_wdata,
  output logic [COMP_W-1:0] host_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [COMP_W-1:0] pix_red,
  output logic [COMP_W-1:0] pix_grn,
  output logic [COMP_W-1:0] pix_blu
);
  localparam int ENT_W = 3 * COMP_W;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // access decode
  logic wr_acc, rd_acc;
  logic ld_wr, ld_rd, dat_wr, dat_rd;
  logic mask_we, state_we, cfg_we;
  assign wr_acc   = host_sel & host_we;
  assign rd_acc   = host_sel & ~host_we;
  assign ld_wr    = wr_acc & (host_addr == RA_WIDX);
  assign ld_rd    = wr_acc & (host_addr == RA_RIDX);
  assign dat_wr   = wr_acc & (host_addr == RA_DATA);
  assign dat_rd   = rd_acc & (host_addr == RA_DATA);
  assign mask_we  = wr_acc & (host_addr == RA_MASK);
  assign state_we = wr_acc & (host_addr == RA_STATE);
  assign cfg_we   = wr_acc & (host_addr == RA_CFG);

  // control registers
  logic [IDX_W-1:0] mask_q;
  logic             hsel_q, dsel_q, vga_q, cfg_mode_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mask_q     <= '1;
      hsel_q     <= 1'b0;
      dsel_q     <= 1'b0;
      vga_q      <= 1'b0;
      cfg_mode_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= host_wdata[IDX_W-1:0];
      if (state_we) begin
        hsel_q <= host_wdata[ST_HSEL];
        dsel_q <= host_wdata[ST_DSEL];
        vga_q  <= host_wdata[ST_VGA];
      end
      if (cfg_we) cfg_mode_q <= host_wdata[0];
    end
  end

  // access sequencer
  logic [IDX_W-1:0]  cur_idx;
  colour_e           cur_colour;
  mode_e             cur_mode;
  logic [COMP_W-1:0] hold_r, hold_g;
  logic              commit;

  pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .ld_wr  (ld_wr),
    .ld_rd  (ld_rd),
    .dat_wr (dat_wr),
    .dat_rd (dat_rd),
    .ld_val (host_wdata[IDX_W-1:0]),
    .dat_in (host_wdata),
    .idx    (cur_idx),
    .colour (cur_colour),
    .mode   (cur_mode),
    .hold_r (hold_r),
    .hold_g (hold_g),
    .commit (commit)
  );

  // width conversion on the store path, one per component
  logic [COMP_W-1:0] raw_comp [3];
  logic [COMP_W-1:0] cell_comp [3];
  assign raw_comp[0] = hold_r;
  assign raw_comp[1] = hold_g;
  assign raw_comp[2] = host_wdata;

  for (genvar c = 0; c < 3; c++) begin : g_wconv
    pal_xlate #(.COMP_W(COMP_W), .TO_CELL(1'b1)) u_up (
      .narrow (vga_q),
      .din    (raw_comp[c]),
      .dout   (cell_comp[c])
    );
  end

  logic [ENT_W-1:0] wentry;
  assign wentry = {cell_comp[0], cell_comp[1], cell_comp[2]};

  // palette storage
  logic [IDX_W-1:0] host_raddr;
  logic [ENT_W-1:0] hentry, dentry;
  assign host_raddr = cur_idx - 1'b1;

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .we     (commit),
    .wsel   (hsel_q),
    .waddr  (cur_idx),
    .wentry (wentry),
    .hsel   (hsel_q),
    .haddr  (host_raddr),
    .hentry (hentry),
    .dsel   (dsel_q),
    .daddr  (pix_idx & mask_q),
    .dentry (dentry)
  );

  assign pix_red = dentry[3*COMP_W-1:2*COMP_W];
  assign pix_grn = dentry[2*COMP_W-1:COMP_W];
  assign pix_blu = dentry[COMP_W-1:0];

  // host read path
  logic [COMP_W-1:0] cell_sel, host_comp;
  always_comb begin
    unique case (cur_colour)
      CLR_R:   cell_sel = hentry[3*COMP_W-1:2*COMP_W];
      CLR_G:   cell_sel = hentry[2*COMP_W-1:COMP_W];
      default: cell_sel = hentry[COMP_W-1:0];
    endcase
  end

  pal_xlate #(.COMP_W(COMP_W), .TO_CELL(1'b0)) u_down (
    .narrow (vga_q),
    .din    (cell_sel),
    .dout   (host_comp)
  );

  logic [COMP_W-1:0] idx_ext, mask_ext, mode_ext, state_ext;
  logic [7:0]        state_byte;
  assign state_byte = {vga_q, dsel_q, cur_mode, hsel_q, cur_colour};

  always_comb begin
    idx_ext   = '0;
    idx_ext[IDX_W-1:0] = cur_idx;
    mask_ext  = '0;
    mask_ext[IDX_W-1:0] = mask_q;
    mode_ext  = '0;
    mode_ext[1:0] = cur_mode;
    state_ext = '0;
    state_ext[7:0] = state_byte;
  end

  logic [COMP_W-1:0] rdata_n, rdata_q;
  always_comb begin
    rdata_n = '0;
    unique case (host_addr)
      RA_DATA:  rdata_n = host_comp;
      RA_WIDX:  rdata_n = idx_ext;
      RA_RIDX:  rdata_n = cfg_mode_q ? mode_ext : idx_ext;
      RA_MASK:  rdata_n = mask_ext;
      RA_STATE: rdata_n = state_ext;
      RA_CFG:   rdata_n[0] = cfg_mode_q;
      default:  rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_n;
  end
  assign host_rdata = rdata_q;
endmodule

// File: rtl/pal_access_ctrl_chk.sv
module pal_access_ctrl_chk
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              host_sel,
  input logic              host_we,
  input logic [2:0]        host_addr,
  input logic [COMP_W-1:0] host_wdata,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [2:0]        cur_colour,
  input logic [1:0]        cur_mode,
  input logic              commit
);
  logic data_acc;
  assign data_acc = host_sel && (host_addr == RA_DATA);

  p_widx_load_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    host_sel && host_we && host_addr == RA_WIDX |=>
      cur_idx == $past(host_wdata[IDX_W-1:0]) && cur_colour == CLR_R && cur_mode == MD_WR);

  p_ridx_load_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    host_sel && host_we && host_addr == RA_RIDX |=>
      cur_idx == IDX_W'($past(host_wdata[IDX_W-1:0]) + 1'b1) && cur_colour == CLR_R && cur_mode == MD_RD);

  p_rg_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    data_acc && host_we && cur_colour != CLR_B |-> !commit);

  p_rg_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    data_acc && cur_colour != CLR_B |=> $stable(cur_idx));

  p_blue_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    data_acc && cur_colour == CLR_B |=>
      cur_colour == CLR_R && cur_idx == IDX_W'($past(cur_idx) + 1'b1));

  p_colour_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones(cur_colour) == 1);

  p_mode_code_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    cur_mode == MD_WR || cur_mode == MD_RD);
endmodule

bind pal_access_ctrl pal_access_ctrl_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
  .clk        (clk),
  .rst_n_int  (rst_n_int),
  .host_sel   (host_sel),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .cur_idx    (cur_idx),
  .cur_colour (cur_colour),
  .cur_mode   (cur_mode),
  .commit     (commit)
);

// File: tb/test_pal_access_ctrl.sv
module test_pal_access_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_sel, host_we;
  logic [2:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic [7:0] pix_idx, pix_red, pix_grn, pix_blu;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pal_access_ctrl i_pal_access_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_idx(pix_idx), .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
  );

  function automatic logic [7:0] pat(int p, int i, int c);
    return 8'(i * 7 + c * 85 + p * 129 + 3);
  endfunction

  function automatic logic [23:0] ent(int p, int i);
    return {pat(p, i, 0), pat(p, i, 1), pat(p, i, 2)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    v = host_rdata;
  endtask

  task automatic disp(logic [7:0] p, output logic [23:0] v);
    @(negedge clk);
    pix_idx = p;
    @(negedge clk);
    v = {pix_red, pix_grn, pix_blu};
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [23:0] e;
    logic [7:0]  masks [3];
    masks[0] = 8'hFF; masks[1] = 8'h0F; masks[2] = 8'hA5;
    rst_n = 1'b0; host_sel = 1'b0; host_we = 1'b0; host_addr = '0;
    host_wdata = '0; pix_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd1, v); chk("R1 index", v, 8'h00);
    rd(3'd4, v); chk("R1 state", v, 8'h01);
    rd(3'd3, v); chk("R1 mask", v, 8'hFF);
    rd(3'd5, v); chk("R1 config", v, 8'h00);

    // R4/R6 fill both palettes
    for (int p = 0; p < 2; p++) begin
      wr(3'd4, p ? 8'h08 : 8'h00);
      wr(3'd1, 8'h00);
      rd(3'd1, v); chk("R2 widx readback", v, 8'h00);
      for (int i = 0; i < 256; i++)
        for (int c = 0; c < 3; c++)
          wr(3'd0, pat(p, i, c));
      rd(3'd1, v); chk("R6 index wraps after 256 triplets", v, 8'h00);
    end

    // R3/R5 read back palette 1 (host select still 1)
    wr(3'd2, 8'h00);
    rd(3'd1, v); chk("R3 ridx loads value plus one", v, 8'h01);
    rd(3'd4, v); chk("R7 state in read mode", v, 8'h39);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        rd(3'd0, v); chk("R5 palette 1 readback", v, pat(1, i, c));
        if (i == 0 && c == 0) begin
          rd(3'd4, v); chk("R6 phase green after one read", v & 8'h07, 8'h02);
        end
      end

    // R3/R5 pointer wrap and palette 0 readback
    wr(3'd4, 8'h00);
    wr(3'd2, 8'hFF);
    rd(3'd1, v); chk("R3 ridx 0xFF wraps to 0", v, 8'h00);
    rd(3'd0, v); chk("R5 read behind pointer 0 hits 255", v, pat(0, 255, 0));
    wr(3'd2, 8'h00);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        rd(3'd0, v); chk("R5 palette 0 readback", v, pat(0, i, c));
      end

    // R10 display sweep: both palettes, several masks
    for (int d = 0; d < 2; d++) begin
      wr(3'd4, d ? 8'h40 : 8'h00);
      for (int m = 0; m < 3; m++) begin
        wr(3'd3, masks[m]);
        for (int p = 0; p < 256; p++) begin
          disp(8'(p), e);
          chk("R10 display lookup", e, ent(d, p & int'(masks[m])));
        end
      end
    end
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h00);

    // R4 partial triplet leaves entry unchanged
    wr(3'd1, 8'd10);
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h22);
    rd(3'd4, v); chk("R4 phase blue after two writes", v, 8'h04);
    rd(3'd1, v); chk("R4 pointer unchanged mid triplet", v, 8'd10);
    disp(8'd10, e); chk("R4 entry untouched mid triplet", e, ent(0, 10));
    wr(3'd0, 8'h33);
    rd(3'd1, v); chk("R6 pointer advances on blue", v, 8'd11);
    disp(8'd10, e); chk("R4 entry stored on blue", e, 24'h112233);

    // R7 read-only fields
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R7 only bits 3,6,7 writable", v, 8'hC9);
    wr(3'd4, 8'h00);

    // R8 width conversion
    wr(3'd4, 8'h80);
    wr(3'd1, 8'd20);
    wr(3'd0, 8'hFF); wr(3'd0, 8'h15); wr(3'd0, 8'h01);
    disp(8'd20, e); chk("R8 stored shifted left", e, 24'hFC5404);
    wr(3'd2, 8'd20);
    rd(3'd0, v); chk("R8 red read shifted right", v, 8'h3F);
    rd(3'd0, v); chk("R8 green read shifted right", v, 8'h15);
    rd(3'd0, v); chk("R8 blue read shifted right", v, 8'h01);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'd20);
    rd(3'd0, v); chk("R8 full width red", v, 8'hFC);
    rd(3'd0, v); chk("R8 full width green", v, 8'h54);
    rd(3'd0, v); chk("R8 full width blue", v, 8'h04);

    // R9 read-index register read selection
    wr(3'd5, 8'h00);
    wr(3'd2, 8'd7);
    rd(3'd2, v); chk("R9 ridx read gives pointer", v, 8'd8);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R9 config readback", v, 8'h01);
    rd(3'd2, v); chk("R9 ridx read gives read mode", v, 8'h03);
    wr(3'd1, 8'd9);
    rd(3'd2, v); chk("R9 ridx read gives write mode", v, 8'h00);
    wr(3'd5, 8'h00);
    rd(3'd2, v); chk("R9 ridx read gives pointer again", v, 8'd9);

    // R11 read data holds
    wr(3'd3, 8'h5A);
    rd(3'd3, v); chk("R11 mask read", v, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds when idle", host_rdata, 8'h5A);
    wr(3'd3, 8'hFF);
    chk("R11 rdata holds across write", host_rdata, 8'h5A);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule